// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block sequences a 10-bit successive-approximation conversion around an external DAC and an external analog comparator. After a start strobe it spends one setup cycle and then tries each result bit in turn, most significant first. Each trial puts the code found so far, plus the bit under test, on the DAC bus for a fixed slot of cycles. At the end of the slot it samples the comparator and keeps or drops that bit. After one finish cycle the code is copied into a result register, a done flag is raised and a one-cycle interrupt pulse is issued. The whole conversion takes exactly 62 clock cycles from the start edge. One clock cycle is one machine cycle.

A second mode makes a single comparison. The host's 8-bit preset drives the upper 8 DAC bits, with the lower bits at zero. The comparator answer is reported 8 cycles after the start, and the result register is left untouched. The host picks one of eight analog channels at start time. It reads the result as 4-bit nibbles: the top eight bits as two nibbles, high nibble first, then a third nibble that carries the two lowest bits in its upper half.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, busy, done, irq, cmp_answer, dac_code and mux_sel are all zero, and every rd_data nibble reads zero.
- R2: With a comparator that outputs 1 when the analog input is at or above the DAC code, a conversion of input value v in 0..1023 yields a result equal to v.
- R3: In conversion mode, busy is 1 from the cycle after the start edge, and done and irq first read 1 exactly 62 cycles after the start edge. Done is still 0 one cycle earlier.
- R4: In conversion mode, the DAC bus reads 10'h200 one cycle after the start edge. Seven cycles after the start edge it holds the decided MSB with bit 8 set as the next trial, so each bit owns a 6-cycle slot.
- R5: In comparator mode, the DAC bus holds the preset in bits 9..2 and zeros in bits 1..0. done first reads 1 exactly 8 cycles after the start edge, with cmp_answer equal to (input >= preset*4). The conversion result is unchanged. A conversion leaves cmp_answer unchanged.
- R6: irq is high for exactly one cycle per completion, and done stays 1 until the next start.
- R7: A start while busy restarts the sequence. Done is cleared at once and rises 62 cycles after the latest start, with the result of the input present during that run.
- R8: rd_sel 0 returns result[9:6], rd_sel 1 returns result[5:2], rd_sel 2 returns {result[1:0],2'b00}, and rd_sel 3 returns 4'b0000.
- R9: mux_sel takes chan_in at the start edge and keeps it through and after the conversion, whatever chan_in does later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one machine cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled on the clock edge |
| cmp_mode | input | 1 | 0 = 10-bit conversion, 1 = single compare against preset |
| chan_in | input | 3 | Analog channel requested with start |
| preset | input | 8 | Compare value for comparator mode |
| cmp_in | input | 1 | Comparator answer, 1 when input >= DAC level |
| rd_sel | input | 2 | Result nibble select |
| dac_code | output | 10 | Code driven to the DAC |
| mux_sel | output | 3 | Latched channel for the analog multiplexer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion flag, cleared by start |
| irq | output | 1 | One-cycle completion pulse |
| cmp_answer | output | 1 | Last comparator-mode answer |
| rd_data | output | 4 | Selected result nibble |

## Verification
A slot counter that is off by one moves the rise of done away from cycle 62 (or cycle 8). It also shifts the second DAC trial away from cycle 7, so the fault shows at the ports within the first few cycles or at completion. A bit index that steps wrongly, or a sampled bit written to the wrong place, shows as a wrong nibble for some of the 1024 swept inputs as soon as that conversion ends. A mode or channel latched at the wrong time shows on dac_code, cmp_answer or mux_sel in the same run.

// File: rtl/sar_pkg.sv
package sar_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_FINISH = 2'd3
    } phase_e;

    // cycles per trial slot once the setup and finish cycles are removed
    function automatic int slot_cycles(input int total, input int trials);
        return (total - 2) / trials;
    endfunction

    function automatic int nibble_count(input int bits);
        return (bits + 3) / 4;
    endfunction
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int RES_BITS    = 10,
    parameter int CONV_CYCLES = 62,
    parameter int CMP_CYCLES  = 8,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_mode,
    output phase_e           phase,
    output logic [IDX_W-1:0] bit_idx,
    output logic             mode_q,
    output logic             sample,
    output logic             finish
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CONV_SLOT = slot_cycles(CONV_CYCLES, RES_BITS);
    localparam int CMP_SLOT  = slot_cycles(CMP_CYCLES, 1);
    localparam int MAX_SLOT  = (CONV_SLOT > CMP_SLOT) ? CONV_SLOT : CMP_SLOT;
    localparam int SLOT_W    = $clog2(MAX_SLOT + 1);
    localparam logic [SLOT_W-1:0] CONV_LAST = SLOT_W'(CONV_SLOT - 1);
    localparam logic [SLOT_W-1:0] CMP_LAST  = SLOT_W'(CMP_SLOT - 1);
    localparam logic [IDX_W-1:0]  TOP_IDX   = IDX_W'(RES_BITS - 1);

    logic [SLOT_W-1:0] slot_cnt;

    always_comb begin
        sample = (phase == PH_TRIAL) && (slot_cnt == (mode_q ? CMP_LAST : CONV_LAST));
        finish = (phase == PH_FINISH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            slot_cnt <= '0;
            bit_idx  <= '0;
            mode_q   <= 1'b0;
        end else if (start) begin
            phase    <= PH_SETUP;
            mode_q   <= cmp_mode;
            slot_cnt <= '0;
            bit_idx  <= TOP_IDX;
        end else begin
            case (phase)
                PH_SETUP: begin
                    phase    <= PH_TRIAL;
                    slot_cnt <= '0;
                end
                PH_TRIAL: begin
                    if (sample) begin
                        slot_cnt <= '0;
                        if (mode_q || bit_idx == '0) phase <= PH_FINISH;
                        else bit_idx <= bit_idx - 1'b1;
                    end else begin
                        slot_cnt <= slot_cnt + 1'b1;
                    end
                end
                PH_FINISH: phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // R3
    finish_after_trial_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FINISH) |-> ($past(phase) == PH_TRIAL));

    // R4
    trial_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_SETUP) && !start) |=> (phase == PH_TRIAL) && (bit_idx == TOP_IDX));
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
    import sar_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int CMP_BITS = 8,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  phase_e              phase,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                mode_q,
    input  logic                sample,
    input  logic                finish,
    input  logic                cmp_in,
    input  logic [CMP_BITS-1:0] preset,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                cmp_answer
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PAD_W = RES_BITS - CMP_BITS;

    logic [RES_BITS-1:0] work;
    logic [RES_BITS-1:0] trial_mask;
    logic [RES_BITS-1:0] low_mask;
    logic [CMP_BITS-1:0] preset_q;

    always_comb begin
        trial_mask = '0;
        if (phase == PH_TRIAL && !mode_q) trial_mask = RES_BITS'(1) << bit_idx;
        low_mask = (trial_mask << 1) - RES_BITS'(1);
        dac_code = mode_q ? {preset_q, {PAD_W{1'b0}}} : (work | trial_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work       <= '0;
            result     <= '0;
            preset_q   <= '0;
            cmp_answer <= 1'b0;
        end else if (start) begin
            work     <= '0;
            preset_q <= preset;
        end else begin
            if (sample && !mode_q) work[bit_idx] <= cmp_in;
            if (sample && mode_q)  cmp_answer    <= cmp_in;
            if (finish && !mode_q) result        <= work;
        end
    end

    // R2
    untried_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_TRIAL) && !mode_q) |-> ((work & low_mask) == '0));

    // R5
    result_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (finish && mode_q && !start) |=> $stable(result));
endmodule

// File: rtl/sar_readout.sv
module sar_readout
    import sar_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int SEL_W    = 2
) (
    input  logic [RES_BITS-1:0] result,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [3:0]          rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NIB   = nibble_count(RES_BITS);
    localparam int PAD_W = NIB * 4 - RES_BITS;

    logic [NIB*4-1:0] padded;

    generate
        if (PAD_W == 0) begin : g_nopad
            assign padded = result;
        end else begin : g_pad
            assign padded = {result, {PAD_W{1'b0}}};
        end
    endgenerate

    always_comb begin
        rd_data = 4'b0000;
        for (int k = 0; k < NIB; k++) begin
            if (rd_sel == SEL_W'(k)) rd_data = padded[(NIB-1-k)*4 +: 4];
        end
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int RES_BITS    = 10,
    parameter int CMP_BITS    = 8,
    parameter int CH_BITS     = 3,
    parameter int CONV_CYCLES = 62,
    parameter int CMP_CYCLES  = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  start,
    input  logic                                  cmp_mode,
    input  logic [CH_BITS-1:0]                    chan_in,
    input  logic [CMP_BITS-1:0]                   preset,
    input  logic                                  cmp_in,
    input  logic [$clog2((RES_BITS+3)/4)-1:0]     rd_sel,
    output logic [RES_BITS-1:0]                   dac_code,
    output logic [CH_BITS-1:0]                    mux_sel,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  irq,
    output logic                                  cmp_answer,
    output logic [3:0]                            rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IDX_W = $clog2(RES_BITS);
    localparam int SEL_W = $clog2(nibble_count(RES_BITS));
    localparam int LAT_W = $clog2(CONV_CYCLES + CMP_CYCLES + 2) + 1;
    localparam logic [LAT_W-1:0] LAT_MAX  = '1;
    localparam logic [LAT_W-1:0] CONV_LAT = LAT_W'(CONV_CYCLES);
    localparam logic [LAT_W-1:0] CMP_LAT  = LAT_W'(CMP_CYCLES);

    phase_e              phase;
    logic [IDX_W-1:0]    bit_idx;
    logic                mode_q;
    logic                sample;
    logic                finish;
    logic [RES_BITS-1:0] result;
    logic [LAT_W-1:0]    lat_cnt;

    sar_sequencer #(
        .RES_BITS(RES_BITS), .CONV_CYCLES(CONV_CYCLES),
        .CMP_CYCLES(CMP_CYCLES), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .cmp_mode(cmp_mode),
        .phase(phase), .bit_idx(bit_idx), .mode_q(mode_q),
        .sample(sample), .finish(finish)
    );

    sar_datapath #(
        .RES_BITS(RES_BITS), .CMP_BITS(CMP_BITS), .IDX_W(IDX_W)
    ) u_dp (
        .clk(clk), .rst(rst), .start(start), .phase(phase),
        .bit_idx(bit_idx), .mode_q(mode_q), .sample(sample),
        .finish(finish), .cmp_in(cmp_in), .preset(preset),
        .dac_code(dac_code), .result(result), .cmp_answer(cmp_answer)
    );

    sar_readout #(
        .RES_BITS(RES_BITS), .SEL_W(SEL_W)
    ) u_rd (
        .result(result), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    assign busy = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            irq     <= 1'b0;
            mux_sel <= '0;
        end else begin
            irq <= finish && !start;
            if (start) begin
                done    <= 1'b0;
                mux_sel <= chan_in;
            end else if (finish) begin
                done <= 1'b1;
            end
        end
    end

    // cycles since the last start edge, used by the latency checks
    always_ff @(posedge clk) begin
        if (rst || start)         lat_cnt <= '0;
        else if (lat_cnt != LAT_MAX) lat_cnt <= lat_cnt + 1'b1;
    end

    // R3
    conv_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !mode_q) |-> (lat_cnt == CONV_LAT));

    // R5
    cmp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && mode_q) |-> (lat_cnt == CMP_LAT));

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7
    start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !done));
endmodule

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       cmp_mode;
    logic [2:0] chan_in;
    logic [7:0] preset;
    logic       cmp_in;
    logic [1:0] rd_sel;
    logic [9:0] dac_code;
    logic [2:0] mux_sel;
    logic       busy, done, irq, cmp_answer;
    logic [3:0] rd_data;

    int vin = 0;
    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    // ideal comparator: 1 when the analog level is at or above the DAC code
    always_comb cmp_in = (vin >= int'(dac_code));

    sar_adc_ctrl i_sar_adc_ctrl (
        .clk(clk), .rst(rst), .start(start), .cmp_mode(cmp_mode),
        .chan_in(chan_in), .preset(preset), .cmp_in(cmp_in), .rd_sel(rd_sel),
        .dac_code(dac_code), .mux_sel(mux_sel), .busy(busy), .done(done),
        .irq(irq), .cmp_answer(cmp_answer), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick(input bit mode, input int ch, input int pre);
        start    = 1'b1;
        cmp_mode = mode;
        chan_in  = 3'(ch);
        preset   = 8'(pre);
        @(negedge clk);
        start = 1'b0;
    endtask

    // read all nibbles, check each, and rebuild the result
    task automatic read_result(input string tag, input int exp);
        int n0, n1, n2, n3;
        rd_sel = 2'd0; #0.4; n0 = int'(rd_data);
        rd_sel = 2'd1; #0.4; n1 = int'(rd_data);
        rd_sel = 2'd2; #0.4; n2 = int'(rd_data);
        rd_sel = 2'd3; #0.4; n3 = int'(rd_data);
        rd_sel = 2'd0;
        chk({tag, " R8 high nibble"}, n0, exp >> 6);
        chk({tag, " R8 mid nibble"},  n1, (exp >> 2) & 15);
        chk({tag, " R8 low nibble"},  n2, (exp & 3) << 2);
        chk({tag, " R8 unused select"}, n3, 0);
        chk({tag, " result"}, (n0 << 6) | (n1 << 2) | (n2 >> 2), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; cmp_mode = 1'b0;
        chan_in = '0; preset = '0; rd_sel = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 cmp_answer", int'(cmp_answer), 0);
        chk("R1 dac_code", int'(dac_code), 0);
        chk("R1 mux_sel", int'(mux_sel), 0);
        read_result("R1", 0);

        // R2 R3 R4 R6 R9: every input code
        for (int v = 0; v < 1024; v++) begin
            vin = v;
            kick(1'b0, v % 8, 0);
            chk("R3 busy after start", int'(busy), 1);
            chk("R7 done cleared by start", int'(done), 0);
            tick(1);
            chk("R4 first trial", int'(dac_code), 512);
            tick(6);
            chk("R4 second trial", int'(dac_code), (v & 512) | 256);
            tick(54);
            chk("R3 done not early", int'(done), 0);
            tick(1);
            chk("R3 done at 62", int'(done), 1);
            chk("R6 irq at completion", int'(irq), 1);
            chk("R3 idle at completion", int'(busy), 0);
            chk("R9 channel latched", int'(mux_sel), v % 8);
            read_result("R2", v);
            tick(1);
            chk("R6 irq one cycle", int'(irq), 0);
            chk("R6 done held", int'(done), 1);
        end

        // R5 comparator mode, both sides of every threshold
        for (int p = 0; p < 256; p++) begin
            for (int off = 0; off >= -1; off--) begin
                int v;
                v = p * 4 + off;
                if (v >= 0) begin
                    vin = v;
                    kick(1'b1, 0, p);
                    tick(1);
                    chk("R5 preset on dac", int'(dac_code), p * 4);
                    tick(6);
                    chk("R5 done not early", int'(done), 0);
                    tick(1);
                    chk("R5 done at 8", int'(done), 1);
                    chk("R5 answer", int'(cmp_answer), (v >= p * 4) ? 1 : 0);
                    if (p % 32 == 0) read_result("R5 result kept", 1023);
                end
            end
        end

        // R5 conversion keeps the comparator answer (last answer was 0)
        vin = 5;
        kick(1'b0, 0, 0);
        tick(62);
        chk("R5 answer kept by conversion", int'(cmp_answer), 0);
        read_result("R2 after compares", 5);

        // R7 restart while busy
        vin = 100;
        kick(1'b0, 1, 0);
        tick(20);
        vin = 700;
        kick(1'b0, 2, 0);
        chk("R7 busy after restart", int'(busy), 1);
        tick(61);
        chk("R7 done not at first deadline", int'(done), 0);
        tick(1);
        chk("R7 done after restart", int'(done), 1);
        chk("R9 channel of restart", int'(mux_sel), 2);
        read_result("R7", 700);

        // R9 channel held against later changes
        vin = 300;
        kick(1'b0, 5, 0);
        tick(3);
        chan_in = 3'd2;
        tick(2);
        chk("R9 channel held mid run", int'(mux_sel), 5);
        tick(57);
        chk("R9 done", int'(done), 1);
        chk("R9 channel held after", int'(mux_sel), 5);
        read_result("R9", 300);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule